// File: doc/BRIEF.md
# Level-2 Multi-Word Interrupt Aggregator

The block collects level-sensitive interrupt source lines, organised as one to four 32-bit words, and funnels them onto a small number of parent interrupt outputs. Every word has its own register window on a simple memory-mapped bus. The window holds a writable enable register and a read-only status register. The status register mirrors the raw source lines, and the block never clears them. A source contributes to a parent when its line is high, its effective enable bit is set, and the parent's fixed routing mask for that word selects it.

Software clears the sources at their origin, so nothing in this block has to be acknowledged. A build-time forward mask sets the enable registers after reset. A build-time wake mask keeps chosen sources live while the system is suspended. Only sources that some parent actually routes can be wake sources. When the system resumes, the stored enables alone apply again.

Top module: `irq_l2_aggregator`

## Requirements
- R1: After reset, the enable register of word w holds bits [32w+31:32w] of the FWD_MASK parameter, and every parent output is 0.
- R2: Word w's window starts at byte address 8*w. A bus write to offset 0x0 (address bit 2 = 0) replaces all 32 enable bits of that word. A bus read returns its data on `bus_rdata_o` one clock after the read strobe, and the data holds until the next read.
- R3: A read at offset 0x4 (address bit 2 = 1) returns the word's raw source lines as sampled at the read strobe. Writes to offset 0x4 leave every enable register unchanged.
- R4: Parent output p equals the OR over all words w of (source AND effective enable AND route(p,w)), registered, so it reflects inputs one clock after they are applied. A source that is not enabled does not reach any parent.
- R5: The routing vector ROUTE_MASK is parent-major: route(p,w) occupies bits [32*(p*NUM_WORDS+w)+31 : 32*(p*NUM_WORDS+w)].
- R6: While `suspend_i` is 1 and WAKE_EN is 1, the effective enable of word w is its stored enable OR (WAKE_MASK word w AND the union over parents of route(p,w)).
- R7: While `suspend_i` is 0, the effective enable equals the stored enable. An enable read during suspend returns the stored value, not the widened one.
- R8: A write to a word index at or beyond NUM_WORDS changes no enable register, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| src_i | input | NUM_WORDS*32 | Level source lines, word 0 in the low bits |
| suspend_i | input | 1 | System suspended; widens enables by the wake set |
| parent_irq_o | output | NUM_PARENTS | Registered parent interrupt lines |

## Verification
The hardest condition to reach is a parent raised only by the wake mask. This needs a source whose stored enable is clear, that is routed to a parent, and that lies in the wake set, and it must be seen while `suspend_i` is high. The stimulus first clears that word's enable through the bus. It then raises the source with suspend set and expects the parent to fire. Next it drops suspend with the source still high and expects the parent to fall. A bus read of the same enable during suspend confirms that the readback never shows the widened value.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // register selected by address bit 2 inside a word window
    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int                        NUM_WORDS = 4,
    parameter int                        ADDR_W    = 5,
    parameter logic [NUM_WORDS*32-1:0]   FWD_MASK  = '0
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      bus_sel_i,
    input  logic                      bus_wr_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  word_t                     bus_wdata_i,
    input  logic [NUM_WORDS*32-1:0]   src_i,
    output logic [NUM_WORDS*32-1:0]   en_o,
    output word_t                     rdata_o
);
    localparam int IDX_W = ADDR_W - 3;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] en;
        word_t                            rdata;
    } regs_t;

    regs_t state_d, state_q;

    logic [NUM_WORDS-1:0][WORD_W-1:0] src_w;
    logic [IDX_W-1:0]                 word_idx;
    reg_sel_e                         reg_sel;
    logic                             unused_addr_bits;

    assign src_w            = src_i;
    assign word_idx         = bus_addr_i[ADDR_W-1:3];
    assign reg_sel          = reg_sel_e'(bus_addr_i[2]);
    assign unused_addr_bits = ^bus_addr_i[1:0];

    always_comb begin
        state_d = state_q;
        if (bus_sel_i && !bus_wr_i) begin
            state_d.rdata = '0;
        end
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_sel_i && (word_idx == IDX_W'(w))) begin
                if (bus_wr_i) begin
                    if (reg_sel == REG_ENABLE) begin
                        state_d.en[w] = bus_wdata_i;
                    end
                end else begin
                    state_d.rdata = (reg_sel == REG_STATUS) ? src_w[w]
                                                            : state_q.en[w];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.en    <= FWD_MASK;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o    = state_q.en;
    assign rdata_o = state_q.rdata;

    // status window writes must not disturb stored enables
    p_stat_write_ignored_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && bus_wr_i && bus_addr_i[2]) |=> $stable(en_o));

    // read data only moves after a read strobe
    p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_sel_i && !bus_wr_i) |=> $stable(rdata_o));
endmodule

// File: rtl/irqagg_wake.sv
module irqagg_wake
    import irqagg_pkg::*;
#(
    parameter int                                   NUM_WORDS   = 4,
    parameter int                                   NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0]  ROUTE_MASK  = '1,
    parameter logic [NUM_WORDS*32-1:0]              WAKE_MASK   = '0,
    parameter bit                                   WAKE_EN     = 1'b1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    suspend_i,
    input  logic [NUM_WORDS*32-1:0] en_i,
    output logic [NUM_WORDS*32-1:0] eff_o
);
    localparam int SLICE = NUM_WORDS * WORD_W;

    function automatic logic [SLICE-1:0] f_routed();
        logic [SLICE-1:0] acc;
        acc = '0;
        for (int p = 0; p < NUM_PARENTS; p++) begin
            acc |= ROUTE_MASK[p*SLICE +: SLICE];
        end
        return acc;
    endfunction

    localparam logic [SLICE-1:0] ROUTED   = f_routed();
    localparam logic [SLICE-1:0] WAKE_SET = WAKE_EN ? (WAKE_MASK & ROUTED) : '0;

    always_comb begin
        eff_o = en_i;
        if (suspend_i) begin
            eff_o = en_i | WAKE_SET;
        end
    end

    // widening during suspend never reaches unrouted sources
    p_wake_routed_only_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((eff_o & ~en_i & ~ROUTED) == '0));
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
#(
    parameter int                                   NUM_WORDS   = 4,
    parameter int                                   NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0]  ROUTE_MASK  = '1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [NUM_WORDS*32-1:0] src_i,
    input  logic [NUM_WORDS*32-1:0] eff_i,
    output logic [NUM_PARENTS-1:0]  parent_o
);
    localparam int SLICE = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic [NUM_PARENTS-1:0] irq;
    } route_t;

    route_t route_d, route_q;
    logic [SLICE-1:0] live;

    assign live = src_i & eff_i;

    generate
        for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_parent
            always_comb begin
                route_d.irq[p] = |(live & ROUTE_MASK[p*SLICE +: SLICE]);
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign parent_o = route_q.irq;

    // a raised parent implies some line was high one clock earlier
    p_parent_needs_src_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (|parent_o) |-> $past(|src_i));

    // quiet inputs give quiet parents one clock later
    p_idle_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_i == '0) |=> (parent_o == '0));
endmodule

// File: rtl/irq_l2_aggregator.sv
module irq_l2_aggregator
    import irqagg_pkg::*;
#(
    parameter int                                   NUM_WORDS   = 4,
    parameter int                                   NUM_PARENTS = 2,
    parameter int                                   ADDR_W      = 5,
    parameter logic [NUM_WORDS*32-1:0]              FWD_MASK    = '0,
    parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0]  ROUTE_MASK  = '1,
    parameter logic [NUM_WORDS*32-1:0]              WAKE_MASK   = '0,
    parameter bit                                   WAKE_EN     = 1'b1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    bus_sel_i,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    input  logic [NUM_WORDS*32-1:0] src_i,
    input  logic                    suspend_i,
    output logic [NUM_PARENTS-1:0]  parent_irq_o
);
    logic [NUM_WORDS*32-1:0] en_q;
    logic [NUM_WORDS*32-1:0] eff_en;

    irqagg_regs #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .FWD_MASK  (FWD_MASK)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .src_i       (src_i),
        .en_o        (en_q),
        .rdata_o     (bus_rdata_o)
    );

    irqagg_wake #(
        .NUM_WORDS   (NUM_WORDS),
        .NUM_PARENTS (NUM_PARENTS),
        .ROUTE_MASK  (ROUTE_MASK),
        .WAKE_MASK   (WAKE_MASK),
        .WAKE_EN     (WAKE_EN)
    ) u_wake (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .suspend_i (suspend_i),
        .en_i      (en_q),
        .eff_o     (eff_en)
    );

    irqagg_route #(
        .NUM_WORDS   (NUM_WORDS),
        .NUM_PARENTS (NUM_PARENTS),
        .ROUTE_MASK  (ROUTE_MASK)
    ) u_route (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .src_i    (src_i),
        .eff_i    (eff_en),
        .parent_o (parent_irq_o)
    );

    // outside suspend the applied enable is exactly the stored one
    p_awake_uses_stored_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !suspend_i |-> (eff_en == en_q));
endmodule

// File: tb/irq_l2_aggregator_test.sv
module irq_l2_aggregator_test;
    localparam int NW = 2;
    localparam int NP = 2;
    localparam int AW = 5;
    localparam logic [NW*32-1:0]    FWD   = {32'h0000_FF00, 32'h0000_000F};
    // parent-major: p0w0, p0w1, p1w0, p1w1 from low to high
    localparam logic [NP*NW*32-1:0] ROUTE = {32'hFFFF_0000, 32'h0000_FF00,
                                             32'h0000_0000, 32'h0000_00FF};
    localparam logic [NW*32-1:0]    WAKE  = {32'h0001_0001, 32'h0001_0001};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NW*32-1:0] src = '0;
    logic          susp = 1'b0;
    logic [NP-1:0] parents;

    always #10 clk = ~clk;

    irq_l2_aggregator #(
        .NUM_WORDS(NW), .NUM_PARENTS(NP), .ADDR_W(AW),
        .FWD_MASK(FWD), .ROUTE_MASK(ROUTE), .WAKE_MASK(WAKE), .WAKE_EN(1'b1)
    ) uut (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .src_i(src), .suspend_i(susp), .parent_irq_o(parents)
    );

    typedef struct {
        string       req;
        int          due;
        bit          is_parent;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [31:0] en_m [NW];

    // monitor: pops items that fall due and compares them with the ports
    always @(negedge clk) begin
        cyc++;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_parent ? {{(32-NP){1'b0}}, parents} : rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] src_word(int w);
        return src[w*32 +: 32];
    endfunction

    function automatic logic [NP-1:0] model_parents();
        logic [NP-1:0] r;
        r = '0;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] uni, eff;
            uni = '0;
            for (int p = 0; p < NP; p++) uni |= ROUTE[(p*NW+w)*32 +: 32];
            eff = en_m[w] | (susp ? (WAKE[w*32 +: 32] & uni) : 32'h0);
            for (int p = 0; p < NP; p++)
                if (|(src_word(w) & eff & ROUTE[(p*NW+w)*32 +: 32])) r[p] = 1'b1;
        end
        return r;
    endfunction

    task automatic slot();
        @(negedge clk);
        #1;
    endtask

    task automatic push(string req, bit is_par, logic [31:0] exp);
        item_t it;
        it.req = req; it.due = cyc + 1; it.is_parent = is_par; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic bus_write(int w, bit stat, logic [31:0] d);
        slot();
        sel = 1'b1; wr = 1'b1; addr = AW'(w*8 + (stat ? 4 : 0)); wdata = d;
        if (!stat && w < NW) en_m[w] = d;
    endtask

    task automatic bus_read(int w, bit stat, string req);
        logic [31:0] e;
        slot();
        sel = 1'b1; wr = 1'b0; addr = AW'(w*8 + (stat ? 4 : 0));
        if (w >= NW) e = 32'h0;
        else e = stat ? src_word(w) : en_m[w];
        push(req, 1'b0, e);
    endtask

    task automatic check_par(logic [NW*32-1:0] s, logic sp, string req);
        slot();
        sel = 1'b0; wr = 1'b0; src = s; susp = sp;
        push(req, 1'b1, {{(32-NP){1'b0}}, model_parents()});
    endtask

    initial begin
        for (int w = 0; w < NW; w++) en_m[w] = FWD[w*32 +: 32];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bus_read(0, 1'b0, "R1");
        bus_read(1, 1'b0, "R1");
        check_par('0, 1'b0, "R1");
        // R4 enabled vs disabled source
        check_par({32'h0, 32'h0000_0001}, 1'b0, "R4");
        check_par({32'h0, 32'h0000_0100}, 1'b0, "R4");
        check_par({32'h0001_0000, 32'h0}, 1'b0, "R4");
        // R2 full-word replace and readback
        bus_write(1, 1'b0, 32'h0001_0000);
        bus_read(1, 1'b0, "R2");
        bus_write(0, 1'b0, 32'h0000_0300);
        bus_read(0, 1'b0, "R2");
        check_par({32'h0, 32'h0000_0002}, 1'b0, "R2");
        // R5 parent-major routing slices
        check_par({32'h0001_0000, 32'h0}, 1'b0, "R5");
        check_par({32'h0, 32'h0000_0200}, 1'b0, "R5");
        check_par({32'h0001_0000, 32'h0000_0100}, 1'b0, "R5");
        // R3 status reads raw lines, writes ignored
        check_par({32'h1234_5678, 32'hA5A5_0000}, 1'b0, "R3");
        bus_read(0, 1'b1, "R3");
        bus_read(1, 1'b1, "R3");
        bus_write(0, 1'b1, 32'hFFFF_FFFF);
        bus_read(0, 1'b0, "R3");
        bus_read(0, 1'b1, "R3");
        // R8 out-of-range window
        bus_write(3, 1'b0, 32'hDEAD_BEEF);
        bus_read(0, 1'b0, "R8");
        bus_read(1, 1'b0, "R8");
        bus_read(3, 1'b0, "R8");
        // R6 wake widening during suspend
        bus_write(1, 1'b0, 32'h0);
        check_par({32'h0001_0000, 32'h0}, 1'b0, "R6");
        check_par({32'h0001_0000, 32'h0}, 1'b1, "R6");
        check_par({32'h0, 32'h0000_0001}, 1'b1, "R6");
        check_par({32'h0001_0000, 32'h0000_0001}, 1'b1, "R6");
        // R7 readback during suspend, then resume
        bus_read(1, 1'b0, "R7");
        check_par({32'h0001_0000, 32'h0}, 1'b0, "R7");
        check_par({32'h0, 32'h0000_0001}, 1'b0, "R7");
        // R4 both parents at once
        bus_write(0, 1'b0, 32'hFFFF_FFFF);
        check_par({32'h0, 32'h0000_0101}, 1'b0, "R4");
        check_par('0, 1'b0, "R4");
        slot();
        sel = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d items left expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule